// File: doc/BRIEF.md
# Byte-Stuffed Frame Receive Decoder

This block sits behind a UART receiver and turns a stream of stuffed bytes back into raw frames. Each byte arrives with a one-cycle valid strobe. A separate strobe reports that the receiver lost a byte. Frames are separated by 0x00. Inside a frame, every group of data begins with a code byte that gives the distance to the next removed zero. The decoder works on the fly: each payload byte is written to a frame buffer one cycle after it arrives, and it does not wait for the frame to end.

When a delimiter arrives, the block reports the decoded length to the next protocol layer with a one-cycle strobe, and it starts the next frame at address 0. After reset, or after the receiver reports a lost byte, the decoder discards everything until it sees a delimiter. If a frame is too long for the buffer, the extra bytes are not stored and the frame is marked with a reserved length. A counter records how many lost-byte events have occurred.

Top module: `cobs_frame_rx`

## Requirements
- R1: While reset is held, and in the first cycle after it, wr_en and eof_valid are low and ovf_count is 0. The decoder comes out of reset hunting for a delimiter.
- R2: While hunting, non-zero bytes are discarded. They cause no write and no end-of-frame report.
- R3: A 0x00 byte accepted in any state (hunting, expecting a code byte, or in payload) gives eof_valid for exactly one cycle. That cycle is the one after the byte is accepted. eof_len equals the number of bytes stored for the frame. The next payload byte is written to address 0, and the decoder then expects a code byte.
- R4: The first non-zero byte after a delimiter is a code byte. It is never written, and it sets the number of bytes remaining before the next stuffed zero.
- R5: Payload bytes are written at consecutive addresses starting at 0. wr_en is high in the cycle after each byte is accepted. Each byte is written unchanged, except when its arrival brings the remaining count to zero. In that case 0x00 is written instead, and the byte's own value becomes the new remaining count.
- R6: A delimiter with no bytes stored gives eof_len = 0. This covers back-to-back delimiters and a delimiter straight after a code byte.
- R7: A frame holds at most MAX_LEN bytes, so wr_addr is always below MAX_LEN. Payload bytes beyond that limit are dropped. Such a frame reports eof_len = 2^LEN_W - 1 (255 by default).
- R8: A cycle with rx_overrun high increments ovf_count, clears the write position and sends the decoder back to hunting. A byte presented in the same cycle is dropped, even a delimiter. The following cycle has no write and no end-of-frame report.
- R9: When SAT_OVF = 1, ovf_count stops at its all-ones value. With SAT_OVF = 0 it wraps to zero.
- R10: Cycles with rx_valid and rx_overrun both low change nothing. wr_en and eof_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | rx_data holds a received byte this cycle |
| rx_data | input | 8 | Received stuffed byte |
| rx_overrun | input | 1 | One-cycle strobe: the receiver lost a byte |
| wr_en | output | 1 | Frame buffer write strobe |
| wr_addr | output | $clog2(MAX_LEN) | Write address within the frame |
| wr_data | output | 8 | Decoded byte to write |
| eof_valid | output | 1 | One-cycle frame end report |
| eof_len | output | LEN_W | Decoded length, or 2^LEN_W-1 if too long |
| ovf_count | output | OVF_W | Number of receiver overrun events |

## Verification
The assertions assume that rx_valid and rx_overrun are synchronous one-cycle strobes sampled on the rising edge, and that rx_data matters only when rx_valid is high. Under these assumptions each accepted byte leads to at most one registered write or one frame-end report in the next cycle. The stimulus changes inputs only on falling edges and presents at most one byte per cycle. It sends well-formed stuffed frames and gapped frames, inserts overrun strobes in the middle of a frame and together with a delimiter, and builds one over-long frame by hand. Expected writes come from the unstuffed payload, not from a model of the decoder.

// File: rtl/cobs_rx_pkg.sv
package cobs_rx_pkg;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_CODE = 2'd1,
      ST_DATA = 2'd2
   } cobs_st_e;

   localparam logic [7:0] DELIM = 8'h00;

   function automatic logic is_delim(input logic [7:0] b);
      return b == DELIM;
   endfunction

endpackage

// File: rtl/cobs_rx_decode.sv
module cobs_rx_decode
   import cobs_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_vld,
   input  logic [7:0] byte_val,
   input  logic       ovr,
   output logic       pay_vld,
   output logic [7:0] pay_byte,
   output logic       delim,
   output cobs_st_e   state_o
);

   cobs_st_e   st, nxt_st;
   logic [7:0] skip, nxt_skip;

   always_comb begin
      pay_vld  = 1'b0;
      pay_byte = byte_val;
      delim    = 1'b0;
      nxt_st   = st;
      nxt_skip = skip;
      if (ovr) begin
         nxt_st = ST_HUNT;
      end else if (byte_vld) begin
         if (is_delim(byte_val)) begin
            delim  = 1'b1;
            nxt_st = ST_CODE;
         end else begin
            unique case (st)
               ST_HUNT: ;
               ST_CODE: begin
                  nxt_skip = byte_val;
                  nxt_st   = ST_DATA;
               end
               ST_DATA: begin
                  pay_vld = 1'b1;
                  if (skip == 8'd1) begin
                     pay_byte = DELIM;
                     nxt_skip = byte_val;
                  end else begin
                     nxt_skip = skip - 8'd1;
                  end
               end
               default: nxt_st = ST_HUNT;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_HUNT;
         skip <= 8'd0;
      end else begin
         st   <= nxt_st;
         skip <= nxt_skip;
      end
   end

   assign state_o = st;

   // R4: while in payload the remaining count is never zero
   assert_skip_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA) |-> (skip != 8'd0));

endmodule

// File: rtl/cobs_rx_frame_wr.sv
module cobs_rx_frame_wr #(
   parameter int MAX_LEN = 254,
   parameter int LEN_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pay_vld,
   input  logic [7:0]                 pay_byte,
   input  logic                       delim,
   input  logic                       clr,
   output logic                       wr_en,
   output logic [$clog2(MAX_LEN)-1:0] wr_addr,
   output logic [7:0]                 wr_data,
   output logic                       eof_valid,
   output logic [LEN_W-1:0]           eof_len
);

   localparam int ADDR_W = $clog2(MAX_LEN);
   localparam int POS_W  = $clog2(MAX_LEN + 1);
   localparam logic [LEN_W-1:0] LEN_BAD = {LEN_W{1'b1}};
   localparam logic [POS_W-1:0] POS_LIM = POS_W'(MAX_LEN);

   logic [POS_W-1:0] pos;
   logic             too_long;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos       <= '0;
         too_long  <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         eof_valid <= 1'b0;
         eof_len   <= '0;
      end else begin
         wr_en     <= 1'b0;
         eof_valid <= 1'b0;
         if (clr) begin
            pos      <= '0;
            too_long <= 1'b0;
         end else if (delim) begin
            eof_valid <= 1'b1;
            eof_len   <= too_long ? LEN_BAD : LEN_W'(pos);
            pos       <= '0;
            too_long  <= 1'b0;
         end else if (pay_vld) begin
            if (pos < POS_LIM) begin
               wr_en   <= 1'b1;
               wr_addr <= ADDR_W'(pos);
               wr_data <= pay_byte;
               pos     <= pos + 1'b1;
            end else begin
               too_long <= 1'b1;
            end
         end
      end
   end

   assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < MAX_LEN));

   assert_len_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eof_valid |-> ((int'(eof_len) <= MAX_LEN) || (eof_len == LEN_BAD)));

endmodule

// File: rtl/cobs_rx_ovf_cnt.sv
module cobs_rx_ovf_cnt #(
   parameter int OVF_W   = 16,
   parameter bit SAT_OVF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovr,
   output logic [OVF_W-1:0] cnt
);

   localparam logic [OVF_W-1:0] CNT_TOP = {OVF_W{1'b1}};

   generate
      if (SAT_OVF) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                     cnt <= '0;
            else if (ovr && cnt != CNT_TOP) cnt <= cnt + 1'b1;
         end

         assert_ovf_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ovr && cnt == CNT_TOP) |=> (cnt == CNT_TOP));

         assert_ovf_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ovr && cnt != CNT_TOP) |=> (cnt == $past(cnt) + 1'b1));
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   cnt <= '0;
            else if (ovr) cnt <= cnt + 1'b1;
         end

         assert_ovf_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ovr |=> (cnt == $past(cnt) + 1'b1));
      end
   endgenerate

   assert_ovf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr |=> $stable(cnt));

endmodule

// File: rtl/cobs_frame_rx.sv
module cobs_frame_rx
   import cobs_rx_pkg::*;
#(
   parameter int MAX_LEN = 254,
   parameter int LEN_W   = 8,
   parameter int OVF_W   = 16,
   parameter bit SAT_OVF = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rx_valid,
   input  logic [7:0]                 rx_data,
   input  logic                       rx_overrun,
   output logic                       wr_en,
   output logic [$clog2(MAX_LEN)-1:0] wr_addr,
   output logic [7:0]                 wr_data,
   output logic                       eof_valid,
   output logic [LEN_W-1:0]           eof_len,
   output logic [OVF_W-1:0]           ovf_count
);

   generate
      if (MAX_LEN < 2) begin : g_bad_max
         $error("cobs_frame_rx: MAX_LEN must be at least 2");
      end
      if (MAX_LEN >= (1 << LEN_W) - 1) begin : g_bad_len
         $error("cobs_frame_rx: LEN_W must leave a length code above MAX_LEN");
      end
      if (OVF_W < 1) begin : g_bad_ovf
         $error("cobs_frame_rx: OVF_W must be positive");
      end
   endgenerate

   logic       pay_vld;
   logic [7:0] pay_byte;
   logic       delim;
   cobs_st_e   dec_st;

   cobs_rx_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_vld (rx_valid),
      .byte_val (rx_data),
      .ovr      (rx_overrun),
      .pay_vld  (pay_vld),
      .pay_byte (pay_byte),
      .delim    (delim),
      .state_o  (dec_st)
   );

   cobs_rx_frame_wr #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .pay_vld   (pay_vld),
      .pay_byte  (pay_byte),
      .delim     (delim),
      .clr       (rx_overrun),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .eof_valid (eof_valid),
      .eof_len   (eof_len)
   );

   cobs_rx_ovf_cnt #(.OVF_W(OVF_W), .SAT_OVF(SAT_OVF)) u_ovf (
      .clk   (clk),
      .rst_n (rst_n),
      .ovr   (rx_overrun),
      .cnt   (ovf_count)
   );

   assert_hunt_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_st == ST_HUNT && rx_valid && rx_data != 8'h00 && !rx_overrun)
         |=> (!wr_en && !eof_valid));

   assert_delim_eof_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_data == 8'h00 && !rx_overrun) |=> eof_valid);

   assert_code_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_st == ST_CODE && rx_valid && rx_data != 8'h00 && !rx_overrun) |=> !wr_en);

   assert_ovr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |=> (!wr_en && !eof_valid));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_valid && !rx_overrun) |=> (!wr_en && !eof_valid));

   assert_wr_eof_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && eof_valid));

endmodule

// File: tb/cobs_frame_rx_bench.sv
module cobs_frame_rx_bench;

   localparam int MAX_LEN = 254;
   localparam int LEN_W   = 8;
   localparam int OVF_W   = 3;
   localparam int AW      = $clog2(MAX_LEN);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_valid = 1'b0;
   logic [7:0]       rx_data = 8'h00;
   logic             rx_overrun = 1'b0;
   logic             wr_en;
   logic [AW-1:0]    wr_addr;
   logic [7:0]       wr_data;
   logic             eof_valid;
   logic [LEN_W-1:0] eof_len;
   logic [OVF_W-1:0] ovf_count;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] exp_wr[$];
   int          exp_eof[$];
   logic [7:0]  pay[$];

   always #2.5 clk = ~clk;

   cobs_frame_rx #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .OVF_W(OVF_W), .SAT_OVF(1'b1)) u_cobs_frame_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_overrun(rx_overrun), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .eof_valid(eof_valid), .eof_len(eof_len), .ovf_count(ovf_count)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: compares outputs against the scoreboard queues
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (wr_en) begin
            if (exp_wr.size() == 0) check("R5 unexpected write (addr<<8|data)", int'({wr_addr, wr_data}), -1);
            else check("R5 write (addr<<8|data)", int'({wr_addr, wr_data}), int'(exp_wr.pop_front()));
         end
         if (eof_valid) begin
            if (exp_eof.size() == 0) check("R3 unexpected eof len", int'(eof_len), -1);
            else check("R3 eof len", int'(eof_len), exp_eof.pop_front());
         end
      end
   end

   task automatic put_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid   = 1'b1;
      rx_data    = b;
      rx_overrun = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid   = 1'b0;
         rx_overrun = 1'b0;
      end
   endtask

   task automatic pulse_ovr(input bit with_byte, input logic [7:0] b);
      @(negedge clk);
      rx_valid   = with_byte;
      rx_data    = b;
      rx_overrun = 1'b1;
   endtask

   // stuff the payload in pay[] (under 254 bytes), expect it back, end with delimiter
   task automatic send_frame(input int gap);
      logic [7:0] enc[$];
      int ci;
      logic [7:0] code;
      enc = {8'h00};
      ci = 0;
      code = 8'd1;
      foreach (pay[i]) begin
         exp_wr.push_back({AW'(i), pay[i]});
         if (pay[i] == 8'h00) begin
            enc[ci] = code;
            ci = enc.size();
            enc.push_back(8'h00);
            code = 8'd1;
         end else begin
            enc.push_back(pay[i]);
            code = code + 8'd1;
         end
      end
      enc[ci] = code;
      foreach (enc[i]) begin
         put_byte(enc[i]);
         if (gap > 0) idle(gap);
      end
      exp_eof.push_back(pay.size());
      put_byte(8'h00);
      idle(1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check("R1 wr_en in reset", int'(wr_en), 0);
      check("R1 eof_valid in reset", int'(eof_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ovf_count after reset", int'(ovf_count), 0);
      check("R1 wr_en after reset", int'(wr_en), 0);

      // R2: bytes before first delimiter are dropped; delimiter while hunting reports 0
      put_byte(8'h05); put_byte(8'h11); put_byte(8'h22);
      exp_eof.push_back(0);
      put_byte(8'h00);
      idle(2);

      // R6: empty frames (back to back delimiters, code followed by delimiter)
      exp_eof.push_back(0); put_byte(8'h00);
      exp_eof.push_back(0); put_byte(8'h01); put_byte(8'h00);
      idle(1);

      // R4 R5: several stuffed patterns
      pay = {8'h00};                      send_frame(0);
      pay = {8'h00, 8'h00};               send_frame(0);
      pay = {8'h11, 8'h22, 8'h00, 8'h33}; send_frame(0);
      pay = {8'h11, 8'h22, 8'h33, 8'h44}; send_frame(0);
      pay = {8'h11, 8'h00, 8'h00, 8'h00}; send_frame(0);
      // R10: same frame with idle gaps between bytes
      pay = {8'hA5, 8'h00, 8'h5A, 8'hFF, 8'h00}; send_frame(3);

      // R8: overrun mid-frame; already written bytes stand, tail dropped, next delimiter reports 0
      exp_wr.push_back({AW'(0), 8'h11});
      exp_wr.push_back({AW'(1), 8'h22});
      put_byte(8'h05); put_byte(8'h11); put_byte(8'h22);
      pulse_ovr(1'b0, 8'h00);
      put_byte(8'h33); put_byte(8'h44);
      idle(1);
      check("R8 ovf_count after one overrun", int'(ovf_count), 1);
      exp_eof.push_back(0);
      put_byte(8'h00);
      idle(1);

      // R8: delimiter in the same cycle as overrun is dropped (no eof expected)
      pulse_ovr(1'b1, 8'h00);
      idle(2);
      check("R8 ovf_count with dropped delimiter", int'(ovf_count), 2);
      exp_eof.push_back(0);
      put_byte(8'h00);
      pay = {8'h42, 8'h00, 8'h43}; send_frame(0);

      // R7: over-long frame, code 0xFF then 254 data bytes, then 2 extra bytes
      put_byte(8'hFF);
      for (int i = 0; i < MAX_LEN; i++) begin
         exp_wr.push_back({AW'(i), 8'((i % 250) + 1)});
         put_byte(8'((i % 250) + 1));
      end
      put_byte(8'h07);
      put_byte(8'h09);
      exp_eof.push_back((1 << LEN_W) - 1);
      put_byte(8'h00);
      idle(1);
      // R3: next frame starts at address 0 again
      pay = {8'h12, 8'h34}; send_frame(0);

      // R9: saturation of the overrun counter
      for (int i = 0; i < 8; i++) pulse_ovr(1'b0, 8'h00);
      idle(2);
      check("R9 ovf_count saturated", int'(ovf_count), 7);
      exp_eof.push_back(0);
      put_byte(8'h00);
      idle(3);

      check("R5 all expected writes seen", exp_wr.size(), 0);
      check("R3 all expected eofs seen", exp_eof.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog R10 actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule